// File: doc/BRIEF.md
# Per-Channel Statistics Update Engine

This block keeps event counters for many traffic channels in an external memory of 16-bit words. Each counter belongs to a channel, to one of two loss-priority classes, and to one of ten counter kinds. On an update strobe the engine works out the word address of the selected counter. It reads that word, adds one, and writes the result back. The two cell-count kinds are 32 bits wide and occupy a low/high word pair. The high word is read and written only when the low word rolls over to zero. Every other kind is a single 16-bit word.

The channel number and the priority bit come either from the cell-event bus or from a selector register that the host loads. A strobe input picks the source. The memory port uses a request/grant handshake, and read data comes back on a separate valid strobe. While an update is running, one further strobe can wait in a holding slot. A strobe that finds the slot full is discarded and reported on a one-cycle overrun pulse.

Top module: `stat_rmw_engine`

## Requirements
- R1: The memory word address is {channel, 2'b00, prio, word}, with word in the low 4 bits and prio at bit 4. Counter code 0 uses words 0 (low) and 1 (high). Code 1 uses words 2 (low) and 3 (high). A code k from 2 to 9 uses the single word k+2.
- R2: A strobe whose resolved channel is all ones, or whose code is 10 to 15, is discarded. It causes no memory access.
- R3: With `evt_src`=0 the channel and prio are taken from `bus_chan`/`bus_prio`. With `evt_src`=1 they are taken from the selector register, which `host_load` writes and which resets to channel 0, prio 0.
- R4: Each accepted update reads the counter word and then writes back that value plus one, modulo 2^16.
- R5: For codes 0 and 1, the high word is read and written back plus one only when the low word's new value is 0. Otherwise only the low word is accessed.
- R6: A 16-bit counter holding 0xFFFF becomes 0x0000. No other word is accessed.
- R7: Code 7 always uses prio 0 in its address, whatever prio is supplied.
- R8: `mem_req` stays high with a stable address, data and `mem_we` until `mem_gnt`. Read data is taken from `mem_rdata` when `mem_rvalid` is high.
- R9: `busy` is 0 after reset. It is high from the first memory request of an update until the grant of that update's last write.
- R10: One strobe can be held while an update runs. A valid strobe that arrives while the holding slot is full and not being drained is dropped. `overrun` then pulses high for one cycle, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Update strobe |
| evt_code | input | 4 | Counter kind to increment |
| evt_src | input | 1 | 0: bus channel/prio, 1: selector register |
| bus_chan | input | CH_W | Channel from the cell-event bus |
| bus_prio | input | 1 | Priority bit from the cell-event bus |
| host_load | input | 1 | Loads the selector register |
| host_chan | input | CH_W | Channel value for the selector register |
| host_prio | input | 1 | Priority value for the selector register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | CH_W+7 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Update in progress |
| overrun | output | 1 | Strobe dropped because the holding slot was full |

## Verification
The bench builds the engine with CH_W=8. This makes the reserved channel 8'hFF reachable and keeps addresses at 15 bits, so a sparse memory model covers every channel it touches. With narrow channels, the rollover cases are set up directly: the bench preloads 0xFFFF into the low words and into the 16-bit words. Grants arrive after a pseudo-random delay, which checks that requests hold steady. Back-to-back strobes fill the holding slot and drive the overrun path.

// File: rtl/stat_rmw_engine.sv
module stat_rmw_engine #(
  parameter int CH_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [3:0]        evt_code,
  input  logic              evt_src,
  input  logic [CH_W-1:0]   bus_chan,
  input  logic              bus_prio,
  input  logic              host_load,
  input  logic [CH_W-1:0]   host_chan,
  input  logic              host_prio,
  output logic              mem_req,
  output logic              mem_we,
  output logic [CH_W+6:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              overrun
);
  localparam int ADDR_W    = CH_W + 7;
  localparam int NUM_CODES = 10;
  localparam int WIDE_CNT  = 2;
  localparam logic [3:0] TAG_CODE = 4'd7;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} state_t;

  state_t            st;
  logic [CH_W-1:0]   sel_chan;
  logic              sel_prio;
  logic              pend_full, pend_prio;
  logic [CH_W-1:0]   pend_chan;
  logic [3:0]        pend_code;
  logic [CH_W-1:0]   cur_chan;
  logic              cur_prio, cur_hi;
  logic [3:0]        cur_code;
  logic [DATA_W-1:0] acc;
  logic              ovr_q;

  function automatic logic [3:0] word_of(input logic [3:0] code);
    if (code < 4'(WIDE_CNT)) return {code[2:0], 1'b0};
    return code + 4'd2;
  endfunction

  logic [CH_W-1:0] src_chan;
  logic            src_prio, evt_ok, pend_take, pend_load, is_wide;

  assign src_chan  = evt_src ? sel_chan : bus_chan;
  assign src_prio  = (evt_code == TAG_CODE) ? 1'b0 : (evt_src ? sel_prio : bus_prio);
  assign evt_ok    = evt_valid && (src_chan != '1) && (evt_code < 4'(NUM_CODES));
  assign pend_take = pend_full && (st == S_IDLE);
  assign pend_load = evt_ok && (!pend_full || pend_take);
  assign is_wide   = cur_code < 4'(WIDE_CNT);

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = acc;
  assign mem_addr  = {cur_chan, 2'b00, cur_prio, word_of(cur_code) + {3'b000, cur_hi}};
  assign busy      = (st != S_IDLE);
  assign overrun   = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_chan <= '0;
      sel_prio <= 1'b0;
    end else if (host_load) begin
      sel_chan <= host_chan;
      sel_prio <= host_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_chan <= '0;
      pend_prio <= 1'b0;
      pend_code <= '0;
      ovr_q     <= 1'b0;
    end else begin
      ovr_q <= evt_ok && pend_full && !pend_take;
      if (pend_load) begin
        pend_full <= 1'b1;
        pend_chan <= src_chan;
        pend_prio <= src_prio;
        pend_code <= evt_code;
      end else if (pend_take) begin
        pend_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_chan <= '0;
      cur_prio <= 1'b0;
      cur_code <= '0;
      cur_hi   <= 1'b0;
      acc      <= '0;
    end else begin
      case (st)
        S_IDLE: if (pend_take) begin
          cur_chan <= pend_chan;
          cur_prio <= pend_prio;
          cur_code <= pend_code;
          cur_hi   <= 1'b0;
          st       <= S_RD;
        end
        S_RD:    if (mem_gnt) st <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          acc <= mem_rdata + 1'b1;
          st  <= S_WR;
        end
        S_WR: if (mem_gnt) begin
          if (!cur_hi && is_wide && acc == '0) begin
            cur_hi <= 1'b1;
            st     <= S_RD;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ADDR_W-1:7] != '1); // R2
  AST_TAG_PRIO0: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_addr[3:0] == 4'd9 |-> !mem_addr[4]); // R7
  AST_HI_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && (mem_addr[3:0] == 4'd1 || mem_addr[3:0] == 4'd3) && $past(mem_we && mem_gnt)
    |-> $past(mem_wdata) == '0); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_we && mem_gnt)); // R9
  AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(pend_full) && $past(evt_valid)); // R10
endmodule

// File: tb/tb_stat_rmw_engine.sv
module tb_stat_rmw_engine;
  localparam int CH_W = 8;
  localparam int AW   = CH_W + 7;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_src = 0, bus_prio = 0, host_load = 0, host_prio = 0;
  logic [3:0] evt_code = 0;
  logic [CH_W-1:0] bus_chan = 0, host_chan = 0;
  logic mem_req, mem_we, mem_gnt = 0, mem_rvalid = 0, busy, overrun;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;

  always #5 clk = ~clk;

  stat_rmw_engine #(.CH_W(CH_W), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code), .evt_src(evt_src),
    .bus_chan(bus_chan), .bus_prio(bus_prio), .host_load(host_load), .host_chan(host_chan),
    .host_prio(host_prio), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .overrun(overrun));

  typedef struct { logic [AW-1:0] addr; logic [15:0] data; string tag; } item_t;
  item_t q[$];
  logic [15:0] mem [int];
  logic [15:0] refm [int];
  int checks = 0, errors = 0, ovr_seen = 0, cycles = 0;
  logic [CH_W-1:0] shadow_chan = 0;
  logic shadow_prio = 0;
  logic [7:0] lf = 8'h5A;

  function automatic logic [AW-1:0] addr_of(logic [CH_W-1:0] ch, logic p, logic [3:0] w);
    return {ch, 2'b00, p, w};
  endfunction

  function automatic logic [15:0] rd(ref logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic preload(logic [AW-1:0] a, logic [15:0] v);
    mem[int'(a)] = v;
    refm[int'(a)] = v;
  endtask

  // driver side: expected writes computed from the requirement text
  task automatic expect_upd(logic src, logic [CH_W-1:0] ch, logic p, logic [3:0] code, string tag);
    logic [CH_W-1:0] c;
    logic pr;
    logic [3:0] w;
    logic [15:0] v;
    c  = src ? shadow_chan : ch;
    pr = (code == 4'd7) ? 1'b0 : (src ? shadow_prio : p);
    if (c == '1 || code > 4'd9) return;
    w = (code == 0) ? 4'd0 : (code == 1) ? 4'd2 : code + 4'd2;
    v = rd(refm, int'(addr_of(c, pr, w))) + 16'd1;
    refm[int'(addr_of(c, pr, w))] = v;
    q.push_back('{addr_of(c, pr, w), v, tag});
    if (code < 2 && v == 0) begin
      v = rd(refm, int'(addr_of(c, pr, w + 4'd1))) + 16'd1;
      refm[int'(addr_of(c, pr, w + 4'd1))] = v;
      q.push_back('{addr_of(c, pr, w + 4'd1), v, tag});
    end
  endtask

  task automatic strobe(logic src, logic [CH_W-1:0] ch, logic p, logic [3:0] code);
    evt_valid = 1; evt_src = src; bus_chan = ch; bus_prio = p; evt_code = code;
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic wait_idle();
    int idle = 0;
    while (idle < 4) begin
      @(negedge clk);
      idle = busy ? 0 : idle + 1;
    end
  endtask

  task automatic ev(logic src, logic [CH_W-1:0] ch, logic p, logic [3:0] code, string tag);
    expect_upd(src, ch, p, code, tag);
    strobe(src, ch, p, code);
    wait_idle();
  endtask

  task automatic hload(logic [CH_W-1:0] ch, logic p);
    host_load = 1; host_chan = ch; host_prio = p;
    @(negedge clk);
    host_load = 0;
    shadow_chan = ch; shadow_prio = p;
  endtask

  // memory model with pseudo-random grant delay
  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_gnt <= rst_n && mem_req && !mem_gnt && (lf[1:0] != 2'b00);
    mem_rvalid <= mem_req && !mem_we && mem_gnt;
    if (mem_req && !mem_we && mem_gnt) mem_rdata <= rd(mem, int'(mem_addr));
    if (mem_req && mem_we && mem_gnt) mem[int'(mem_addr)] = mem_wdata;
  end

  // monitor: pop and compare each granted write
  always @(posedge clk) begin
    if (rst_n && overrun) ovr_seen++;
    if (rst_n && mem_req && mem_we && mem_gnt) begin
      if (q.size() == 0) begin
        check(0, "R2", "unexpected write addr", int'(mem_addr), 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(mem_addr == it.addr, it.tag, "write addr", int'(mem_addr), int'(it.addr));
        check(mem_wdata == it.data, it.tag, "write data", int'(mem_wdata), int'(it.data));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R9", "busy in reset", busy, 0);
    check(mem_req == 0, "R8", "req in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    check(overrun == 0, "R10", "overrun after reset", overrun, 0);

    ev(1, 8'h33, 1, 4'd3, "R3");
    ev(0, 8'h12, 1, 4'd0, "R1");
    ev(0, 8'h12, 1, 4'd1, "R1");
    ev(0, 8'h34, 0, 4'd9, "R1");
    ev(0, 8'h34, 0, 4'd9, "R4");
    preload(addr_of(8'h50, 0, 4'd4), 16'h0FFF);
    ev(0, 8'h50, 0, 4'd2, "R4");

    preload(addr_of(8'h21, 1, 4'd0), 16'hFFFF);
    preload(addr_of(8'h21, 1, 4'd1), 16'h1234);
    ev(0, 8'h21, 1, 4'd0, "R5");
    preload(addr_of(8'h22, 0, 4'd2), 16'hFFFF);
    preload(addr_of(8'h22, 0, 4'd3), 16'hFFFF);
    ev(0, 8'h22, 0, 4'd1, "R5");
    preload(addr_of(8'h23, 0, 4'd2), 16'h0010);
    preload(addr_of(8'h23, 0, 4'd3), 16'h0777);
    ev(0, 8'h23, 0, 4'd1, "R5");

    preload(addr_of(8'h60, 1, 4'd7), 16'hFFFF);
    preload(addr_of(8'h60, 1, 4'd8), 16'h0042);
    ev(0, 8'h60, 1, 4'd5, "R6");
    ev(0, 8'h60, 1, 4'd6, "R6");

    ev(0, 8'h40, 1, 4'd7, "R7");
    hload(8'h7E, 1);
    ev(1, 8'h7E, 1, 4'd7, "R7");

    ev(1, 8'h01, 0, 4'd8, "R3");
    ev(1, 8'h02, 0, 4'd0, "R3");

    strobe(0, 8'hFF, 0, 4'd4);
    strobe(0, 8'h10, 0, 4'd12);
    hload(8'hFF, 0);
    strobe(1, 8'h10, 0, 4'd2);
    repeat (8) @(negedge clk);
    check(busy == 0, "R2", "busy after dropped strobes", busy, 0);
    hload(8'h05, 0);

    expect_upd(0, 8'h70, 0, 4'd2, "R10");
    strobe(0, 8'h70, 0, 4'd2);
    expect_upd(0, 8'h71, 0, 4'd3, "R10");
    strobe(0, 8'h71, 0, 4'd3);
    check(busy == 1, "R9", "busy during update", busy, 1);
    strobe(0, 8'h72, 0, 4'd4);
    check(overrun == 1, "R10", "overrun pulse", overrun, 1);
    @(negedge clk);
    check(overrun == 0, "R10", "overrun one cycle", overrun, 0);
    wait_idle();
    check(ovr_seen == 1, "R10", "overrun count", ovr_seen, 1);
    check(q.size() == 0, "R4", "pending expected writes", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule